// File: doc/BRIEF.md
# Static Memory Write-Cycle Sequencer with Ready Wait

This block runs one write access at a time to an external asynchronous static device. A request on the system side carries an address, byte enables and write data. The block captures them together with the timing configuration of the access and then shapes two active-low strobes, chip select and write enable. Each strobe has its own setup, pulse and hold length. Address, data and byte enables stay on the bus pins, unchanged, for the whole access.

An active-low wait input from the device crosses into the clock domain through a synchronizer. In ready mode the synchronized wait is looked at in exactly one cycle: the last pulse cycle of the strobe chosen as the controlling one. If wait is low in that cycle, the whole access freezes with both strobes held as they are. When wait rises again, the access resumes and its hold phases run. A one-cycle acknowledge marks the final cycle of the access.

Top module: `sws_write_seq`

## Requirements
- R1: While idle, and after reset, `ext_cs_n` and `ext_we_n` are high, `ext_be_n` is all ones and `req_ack` is low.
- R2: A request is taken only while idle, at the clock edge where `req_valid` is high. Address, data, byte enables and all configuration are captured at that edge. `ext_be_n` is the bitwise inverse of the captured enables. The bus values stay constant until the access ends, and `req_valid` pulses during an access have no effect.
- R3: Cycle 0 is the first cycle after the accepting edge. `ext_cs_n` is low starting at cycle `cfg_cs_setup`, for the effective chip-select pulse length plus any frozen cycles that fall inside that pulse.
- R4: `ext_we_n` is low starting at cycle `cfg_we_setup`, for the effective write pulse length plus any frozen cycles that fall inside that pulse.
- R5: A pulse length of 0 is treated as a 1-cycle pulse.
- R6: With no freeze, an access lasts the larger of (setup + effective pulse + hold) of the two strobes. `req_ack` is high only in the final cycle, and only for one cycle per access.
- R7: `ext_wait_n` passes through a 2-stage synchronizer. A level present at the clock edge that closes cycle k acts on the sequencer in cycle k+2.
- R8: With `cfg_ready_en`=1, a synchronized low wait in the controlling strobe's last pulse cycle freezes the access. Both strobes keep their levels, and the access grows by one cycle for each cycle that the synchronized wait stays low.
- R9: After the synchronized wait rises, the access continues from the frozen point. Remaining pulse and hold cycles of both strobes run normally, and the access then completes.
- R10: Wait that is low only before the sample cycle, or that falls only after it, leaves the access length unchanged.
- R11: With `cfg_ready_en`=0, the wait input never changes the access.
- R12: `cfg_we_ctrl`=1 places the sample cycle at the last write-enable pulse cycle. `cfg_we_ctrl`=0 places it at the last chip-select pulse cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Write request |
| req_addr | input | ADDR_W | Write address |
| req_be | input | DATA_W/8 | Byte enables, active high |
| req_data | input | DATA_W | Write data |
| req_ack | output | 1 | One-cycle pulse in the final cycle of the access |
| cfg_cs_setup | input | 6 | Chip-select setup cycles |
| cfg_cs_pulse | input | 6 | Chip-select pulse cycles (0 acts as 1) |
| cfg_cs_hold | input | 6 | Chip-select hold cycles |
| cfg_we_setup | input | 6 | Write-enable setup cycles |
| cfg_we_pulse | input | 6 | Write-enable pulse cycles (0 acts as 1) |
| cfg_we_hold | input | 6 | Write-enable hold cycles |
| cfg_ready_en | input | 1 | 1 = the wait input may stretch the access |
| cfg_we_ctrl | input | 1 | 1 = write enable sets the sample cycle, 0 = chip select sets it |
| ext_wait_n | input | 1 | Device wait, active low, asynchronous |
| ext_cs_n | output | 1 | Chip select, active low |
| ext_we_n | output | 1 | Write enable, active low |
| ext_addr | output | ADDR_W | Bus address |
| ext_be_n | output | DATA_W/8 | Byte enables, active low |
| ext_data | output | DATA_W | Bus write data |

## Verification
Strobe timing is tried with overlapping windows where chip select outlasts write enable, with the reverse case, with zero-length fields and with the largest setup. These cases show the per-strobe start, width and length-of-access arithmetic apart from one another. Wait is driven as a window placed relative to the sample cycle: one window covers the sample cycle, one ends just before it, one starts after it, and a pair of one-cycle pulses sits one clock apart around the synchronizer latency. These windows separate a correct sample point from one that is off by one, a missing freeze and a sticky freeze. The same covering window is repeated with ready mode off and with chip select as the controlling strobe, to show that the mode bit and the controller choice matter.

// File: rtl/sws_pkg.sv
package sws_pkg;
  localparam int CNT_W  = 6;
  localparam int TICK_W = CNT_W + 2;

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [TICK_W-1:0] tick_t;

  typedef struct packed {
    cnt_t setup;
    cnt_t pulse;
    cnt_t hold;
  } win_cfg_t;

  localparam int CS_IDX = 0;
  localparam int WE_IDX = 1;
  localparam int N_STROBE = 2;

  function automatic tick_t pulse_len(input cnt_t p);
    return (p == '0) ? tick_t'(1) : tick_t'(p);
  endfunction

  function automatic tick_t pulse_first(input win_cfg_t c);
    return tick_t'(c.setup);
  endfunction

  // exclusive end of the pulse
  function automatic tick_t pulse_stop(input win_cfg_t c);
    return pulse_first(c) + pulse_len(c.pulse);
  endfunction

  function automatic tick_t window_len(input win_cfg_t c);
    return pulse_stop(c) + tick_t'(c.hold);
  endfunction

  function automatic tick_t tick_max(input tick_t a, input tick_t b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sws_sync.sv
module sws_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  // STAGES must be 2 or more; the chain resets to the idle (high) level
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sws_strobe_win.sv
module sws_strobe_win
  import sws_pkg::*;
(
  input  tick_t    tick_i,
  input  win_cfg_t cfg_i,
  output logic     on_o,
  output logic     last_o,
  output tick_t    len_o
);
  tick_t first_t, stop_t;

  always_comb begin
    first_t = pulse_first(cfg_i);
    stop_t  = pulse_stop(cfg_i);
    on_o    = (tick_i >= first_t) && (tick_i < stop_t);
    last_o  = (tick_i == stop_t - tick_t'(1));
    len_o   = window_len(cfg_i);
  end
endmodule

// File: rtl/sws_write_seq.sv
module sws_write_seq
  import sws_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  localparam int BE_W       = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  input  logic [DATA_W-1:0] req_data,
  output logic              req_ack,
  input  logic [CNT_W-1:0]  cfg_cs_setup,
  input  logic [CNT_W-1:0]  cfg_cs_pulse,
  input  logic [CNT_W-1:0]  cfg_cs_hold,
  input  logic [CNT_W-1:0]  cfg_we_setup,
  input  logic [CNT_W-1:0]  cfg_we_pulse,
  input  logic [CNT_W-1:0]  cfg_we_hold,
  input  logic              cfg_ready_en,
  input  logic              cfg_we_ctrl,
  input  logic              ext_wait_n,
  output logic              ext_cs_n,
  output logic              ext_we_n,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [BE_W-1:0]   ext_be_n,
  output logic [DATA_W-1:0] ext_data
);
  // captured request state
  logic              busy_q;
  tick_t             tick_q;
  win_cfg_t          win_q [N_STROBE];
  logic              ready_q, we_ctrl_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BE_W-1:0]   be_q;
  logic [DATA_W-1:0] data_q;

  // named internal events
  logic                win_on   [N_STROBE];
  logic                win_last [N_STROBE];
  tick_t               win_len  [N_STROBE];
  tick_t               end_tick, tick_last;
  logic                wait_sync_n, wait_seen;
  logic                accept, sample_hit, hold_now, at_end, step;

  sws_sync #(.STAGES(SYNC_STAGES)) u_wait_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (ext_wait_n),
    .q_o  (wait_sync_n)
  );

  for (genvar g = 0; g < N_STROBE; g++) begin : g_win
    sws_strobe_win u_win (
      .tick_i(tick_q),
      .cfg_i (win_q[g]),
      .on_o  (win_on[g]),
      .last_o(win_last[g]),
      .len_o (win_len[g])
    );
  end

  always_comb begin
    accept     = req_valid && !busy_q;
    end_tick   = tick_max(win_len[CS_IDX], win_len[WE_IDX]);
    tick_last  = end_tick - tick_t'(1);
    wait_seen  = !wait_sync_n;
    sample_hit = busy_q && (we_ctrl_q ? win_last[WE_IDX] : win_last[CS_IDX]);
    hold_now   = sample_hit && ready_q && wait_seen;
    at_end     = busy_q && (tick_q == tick_last);
    step       = busy_q && !hold_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      tick_q    <= '0;
      ready_q   <= 1'b0;
      we_ctrl_q <= 1'b0;
      addr_q    <= '0;
      be_q      <= '0;
      data_q    <= '0;
      for (int i = 0; i < N_STROBE; i++) win_q[i] <= '0;
    end else if (accept) begin
      busy_q        <= 1'b1;
      tick_q        <= '0;
      ready_q       <= cfg_ready_en;
      we_ctrl_q     <= cfg_we_ctrl;
      addr_q        <= req_addr;
      be_q          <= req_be;
      data_q        <= req_data;
      win_q[CS_IDX] <= '{setup: cfg_cs_setup, pulse: cfg_cs_pulse, hold: cfg_cs_hold};
      win_q[WE_IDX] <= '{setup: cfg_we_setup, pulse: cfg_we_pulse, hold: cfg_we_hold};
    end else if (step) begin
      if (at_end) busy_q <= 1'b0;
      else        tick_q <= tick_q + tick_t'(1);
    end
  end

  assign req_ack  = at_end && !hold_now;
  assign ext_cs_n = !(busy_q && win_on[CS_IDX]);
  assign ext_we_n = !(busy_q && win_on[WE_IDX]);
  assign ext_addr = addr_q;
  assign ext_data = data_q;
  assign ext_be_n = busy_q ? ~be_q : '1;

  // R1: strobes stay released while no access runs
  p_idle_strobes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (ext_cs_n && ext_we_n && !req_ack));

  // R2: bus values do not move during an access
  p_bus_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> ($stable(ext_addr) && $stable(ext_data) && $stable(ext_be_n)));

  // R6: acknowledge is a single-cycle pulse that ends the access
  p_ack_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> (!req_ack && !busy_q));

  // R8: a frozen cycle keeps both strobes where they were
  p_freeze_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_now |=> ($stable(ext_cs_n) && $stable(ext_we_n) && busy_q));

  // R9: the access position does not advance while frozen
  p_freeze_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_now && !accept) |=> (tick_q == $past(tick_q)));
endmodule

// File: tb/sws_write_seq_tb.sv
module sws_write_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;
  localparam int NF = 15;
  // css csp csh wes wep weh rdy wctl wa wl | tot csn wen csf wef
  localparam int VT [NV][NF] = '{
    '{ 1, 7, 1,  2, 5, 1, 1, 1, 0, 0,  9,  7,  5,  1,  2},
    '{ 1, 7, 1,  2, 5, 1, 1, 1, 3, 4, 12, 10,  8,  1,  2},
    '{ 1, 7, 1,  2, 5, 1, 1, 1, 0, 3,  9,  7,  5,  1,  2},
    '{ 1, 7, 1,  2, 5, 1, 1, 1, 6, 5,  9,  7,  5,  1,  2},
    '{ 1, 7, 1,  2, 5, 1, 0, 1, 3, 4,  9,  7,  5,  1,  2},
    '{ 1, 7, 1,  2, 5, 1, 1, 0, 4, 6, 14, 12,  5,  1,  2},
    '{ 0, 0, 0,  0, 0, 0, 1, 1, 0, 0,  1,  1,  1,  0,  0},
    '{ 0, 2, 0,  1, 3, 4, 1, 1, 0,10, 17,  2, 12,  0,  1},
    '{63, 1, 0, 63, 1, 0, 1, 1, 0, 0, 64,  1,  1, 63, 63},
    '{ 0, 4, 0,  0, 4, 0, 1, 1, 1, 1,  5,  5,  5,  0,  0},
    '{ 0, 4, 0,  0, 4, 0, 1, 1, 2, 1,  4,  4,  4,  0,  0}
  };

  function automatic string len_tag(input int v);
    case (v)
      1:       return "R8";
      2, 3:    return "R10";
      4:       return "R11";
      5:       return "R12";
      6:       return "R5";
      7:       return "R9";
      9, 10:   return "R7";
      default: return "R6";
    endcase
  endfunction

  logic        clk, rst_n;
  logic        req_valid, req_ack;
  logic [23:0] req_addr, ext_addr;
  logic [3:0]  req_be, ext_be_n;
  logic [31:0] req_data, ext_data;
  logic [5:0]  cfg_cs_setup, cfg_cs_pulse, cfg_cs_hold;
  logic [5:0]  cfg_we_setup, cfg_we_pulse, cfg_we_hold;
  logic        cfg_ready_en, cfg_we_ctrl, ext_wait_n, ext_cs_n, ext_we_n;

  int checks = 0;
  int errors = 0;

  sws_write_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_be(req_be), .req_data(req_data), .req_ack(req_ack),
    .cfg_cs_setup(cfg_cs_setup), .cfg_cs_pulse(cfg_cs_pulse), .cfg_cs_hold(cfg_cs_hold),
    .cfg_we_setup(cfg_we_setup), .cfg_we_pulse(cfg_we_pulse), .cfg_we_hold(cfg_we_hold),
    .cfg_ready_en(cfg_ready_en), .cfg_we_ctrl(cfg_we_ctrl), .ext_wait_n(ext_wait_n),
    .ext_cs_n(ext_cs_n), .ext_we_n(ext_we_n), .ext_addr(ext_addr),
    .ext_be_n(ext_be_n), .ext_data(ext_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_be = '0; req_data = '0;
    cfg_cs_setup = '0; cfg_cs_pulse = '0; cfg_cs_hold = '0;
    cfg_we_setup = '0; cfg_we_pulse = '0; cfg_we_hold = '0;
    cfg_ready_en = 1'b0; cfg_we_ctrl = 1'b0; ext_wait_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset / idle state
    chk(ext_cs_n == 1'b1, "R1 cs_n idle", int'(ext_cs_n), 1);
    chk(ext_we_n == 1'b1, "R1 we_n idle", int'(ext_we_n), 1);
    chk(req_ack == 1'b0, "R1 ack idle", int'(req_ack), 0);
    chk(ext_be_n == 4'hF, "R1 be_n idle", int'(ext_be_n), 15);

    for (int v = 0; v < NV; v++) begin
      int tot, cs_cnt, we_cnt, cs_first, we_first, ack_cnt, bus_bad;
      logic [23:0] e_addr;
      logic [31:0] e_data;
      logic [3:0]  e_be;
      bit done;
      tot = -1; cs_cnt = 0; we_cnt = 0; cs_first = -1; we_first = -1;
      ack_cnt = 0; bus_bad = 0; done = 1'b0;
      e_addr = 24'h0A0000 + 24'(v * 17);
      e_data = 32'hC0DE0000 ^ 32'(v * 4099);
      e_be   = 4'(v + 5);
      cfg_cs_setup = 6'(VT[v][0]); cfg_cs_pulse = 6'(VT[v][1]); cfg_cs_hold = 6'(VT[v][2]);
      cfg_we_setup = 6'(VT[v][3]); cfg_we_pulse = 6'(VT[v][4]); cfg_we_hold = 6'(VT[v][5]);
      cfg_ready_en = VT[v][6][0]; cfg_we_ctrl = VT[v][7][0];
      req_addr = e_addr; req_data = e_data; req_be = e_be; req_valid = 1'b1;
      for (int c = 0; c < 200; c++) begin
        @(negedge clk);
        if (c == 0) begin
          req_valid = 1'b0;
          // config changes after accept must not matter (R2)
          cfg_cs_pulse = 6'd30; cfg_we_pulse = 6'd30; cfg_ready_en = ~cfg_ready_en;
        end
        if (!done) begin
          if (ext_addr != e_addr || ext_data != e_data || ext_be_n != ~e_be) bus_bad++;
        end
        if (!ext_cs_n) begin cs_cnt++; if (cs_first < 0) cs_first = c; end
        if (!ext_we_n) begin we_cnt++; if (we_first < 0) we_first = c; end
        if (req_ack) begin ack_cnt++; if (tot < 0) tot = c + 1; done = 1'b1; end
        ext_wait_n = !(c >= VT[v][8] && c < VT[v][8] + VT[v][9]);
        if (VT[v][10] >= 4) begin
          if (c == 1) begin req_valid = 1'b1; req_addr = ~e_addr; req_data = ~e_data; end
          if (c == 2) req_valid = 1'b0;
        end
        if (done && c >= tot + 2) break;
      end
      ext_wait_n = 1'b1;
      chk(tot == VT[v][10], len_tag(v), tot, VT[v][10]);
      chk(cs_cnt == VT[v][11], "R3 cs low cycles", cs_cnt, VT[v][11]);
      chk(we_cnt == VT[v][12], "R4 we low cycles", we_cnt, VT[v][12]);
      chk(cs_first == VT[v][13], "R3 cs start", cs_first, VT[v][13]);
      chk(we_first == VT[v][14], "R4 we start", we_first, VT[v][14]);
      chk(ack_cnt == 1, "R6 ack count", ack_cnt, 1);
      chk(bus_bad == 0, "R2 bus hold", bus_bad, 0);
      repeat (3) @(negedge clk);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule